// File: doc/BRIEF.md
# Flow-Controlled Serial Link UART

This block is a byte-oriented asynchronous serial port meant to carry a host transport link between two chips on one board. A processor talks to it through a small register bus: it pushes bytes into a 128-entry transmit queue, pops received bytes from a 128-entry receive queue, and sets a baud divisor, interrupt thresholds and a receive high-water mark. On the line side every character has one start bit, eight data bits sent least significant first and one stop bit. There is no parity.

Flow control runs in hardware in both directions. The transmitter starts a character only while the far end's clear-to-send input is high. A character already on the wire always finishes. The request-to-send output drops as soon as the receive queue reaches the high-water mark. It rises again only when software has drained the queue below the receive threshold. A sender that honours this signal therefore stops after at most one further character. The bit clock is a 16x oversampling tick, made by dividing the system clock by a programmable divisor. After reset the divisor is set for 57.6 kbit/s from a 13 MHz clock.

Top module: `uart_link`

## Requirements
- R1: While `rst_n` is low, `txd_oe` is 0. After reset, `txd_oe` is 1, `txd` is 1 and `rts` is 1. Both queues are empty, the divisor reads 14, the high-water mark reads 120, the receive threshold reads 1, the transmit threshold reads 0 and `irq` is 1.
- R2: Each transmitted character is a start bit (0), then eight data bits least significant first, then a stop bit (1). Each bit lasts 16 ticks, and one tick is `divisor` clock cycles; a divisor of 0 behaves as 1.
- R3: The transmit queue holds 128 bytes and sends them in write order. A write to a full queue is dropped. Status bit 1 reports that the queue is full and bit 2 that it is empty.
- R4: The receive queue holds 128 bytes and returns them in arrival order. A character that arrives while the queue is full is discarded. The fill level reads at offset 7.
- R5: No character starts while `cts` (after a two-flop synchronizer) is 0. A character already started when `cts` falls is sent in full.
- R6: `rts` goes to 0 once the receive fill is at or above the high-water mark. It returns to 1 only when the fill is below the receive threshold, and it holds its value in between.
- R7: The receiver confirms the start bit half a bit after the falling edge and samples each data bit and the stop bit at mid-bit. A stop bit of 0 sets the framing-error flag (status bit 3) and the byte is discarded. The receiver then waits for the line to go high before looking for a new start. A read of the status register clears the flag.
- R8: The receive interrupt (status bit 4, also on `irq`) is 1 when the receive fill is nonzero and at or above the receive threshold. The threshold is capped at 127 when written.
- R9: The transmit interrupt (status bit 5, also on `irq`) is 1 when the transmit fill is at or below the transmit threshold. The threshold is capped at 128 when written.
- R10: Register offsets are: 0 data (a write queues a byte, a read pops one), 1 divisor low, 2 divisor high, 3 receive threshold, 4 transmit threshold, 5 high-water mark, 6 status, 7 receive fill. Status bits from 7 down to 0 are: busy, rts, tx interrupt, rx interrupt, framing error, tx empty, tx full, rx available.
- R11: A low pulse on `rxd` shorter than half a bit is rejected as noise and queues no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as `cs` |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Far end allows sending when 1 |
| txd | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Output enable for `txd`, 0 during reset |
| rts | output | 1 | Far end may send when 1 |
| irq | output | 1 | OR of the receive and transmit interrupts |

## Verification
The assertions assume that `cts` and `rxd` may change at any time, because both are resynchronized, but that bus strobes are clean single-cycle pulses. They also assume the divisor is not rewritten while a character is on the wire. The bench keeps to this: it changes the divisor only when both directions are idle, and it drives the bus and the serial inputs on falling clock edges. Most traffic is looped back from `txd` into `rxd`, so each byte is checked on the wire and again after it lands in the receive queue. Framing errors and noise pulses come from a directly driven receive line.

// File: rtl/uart_link.sv
module uart_link #(
  parameter int CLK_HZ    = 13_000_000,
  parameter int BAUD      = 57_600,
  parameter int DEPTH     = 128,
  parameter int HWM_RESET = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  input  logic       cts,
  output logic       txd,
  output logic       txd_oe,
  output logic       rts,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [15:0] DIV_RESET = 16'((CLK_HZ + 8 * BAUD) / (16 * BAUD));
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rx_st_e;

  logic [15:0] div_q, bcnt;
  logic [7:0]  rx_thr_q, tx_thr_q, hwm_q;
  logic        tick;

  wire wr      = cs & we;
  wire rd      = cs & ~we;
  wire stat_rd = rd && addr == 3'd6;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q    <= DIV_RESET;
      rx_thr_q <= 8'd1;
      tx_thr_q <= 8'd0;
      hwm_q    <= 8'(HWM_RESET);
    end else if (wr) begin
      case (addr)
        3'd1: div_q[7:0]  <= wdata;
        3'd2: div_q[15:8] <= wdata;
        3'd3: rx_thr_q    <= (wdata > 8'd127) ? 8'd127 : wdata;
        3'd4: tx_thr_q    <= (wdata > 8'd128) ? 8'd128 : wdata;
        3'd5: hwm_q       <= wdata;
        default: ;
      endcase
    end

  wire [15:0] div_eff = (div_q == 16'd0) ? 16'd1 : div_q;
  assign tick = bcnt >= div_eff - 16'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bcnt <= '0;
    else if (tick) bcnt <= '0;
    else           bcnt <= bcnt + 16'd1;

  logic cts_m, cts_s, rxd_m, rxd_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_m <= 1'b0; cts_s <= 1'b0;
      rxd_m <= 1'b1; rxd_s <= 1'b1;
    end else begin
      cts_m <= cts;  cts_s <= cts_m;
      rxd_m <= rxd;  rxd_s <= rxd_m;
    end

  // transmit queue
  logic [7:0]    tx_mem [DEPTH];
  logic [AW:0]   tx_wr, tx_rd;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_empty, tx_push, tx_start, tx_busy;
  logic [9:0]    tx_sh;
  logic [3:0]    tx_tc, tx_bc;

  assign tx_cnt   = tx_wr - tx_rd;
  assign tx_full  = tx_cnt == FULL;
  assign tx_empty = tx_cnt == '0;
  assign tx_push  = wr && addr == 3'd0 && !tx_full;
  assign tx_start = tick && !tx_busy && !tx_empty && cts_s;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wr[AW-1:0]] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wr <= '0; tx_rd <= '0;
    end else begin
      if (tx_push)  tx_wr <= tx_wr + 1'b1;
      if (tx_start) tx_rd <= tx_rd + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_tc   <= '0;
      tx_bc   <= '0;
    end else if (tx_start) begin
      tx_busy <= 1'b1;
      tx_sh   <= {1'b1, tx_mem[tx_rd[AW-1:0]], 1'b0};
      tx_tc   <= '0;
      tx_bc   <= '0;
    end else if (tx_busy && tick) begin
      if (tx_tc == 4'd15) begin
        tx_tc <= '0;
        tx_sh <= {1'b1, tx_sh[9:1]};
        if (tx_bc == 4'd9) tx_busy <= 1'b0;
        else               tx_bc   <= tx_bc + 4'd1;
      end else begin
        tx_tc <= tx_tc + 4'd1;
      end
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) txd_oe <= 1'b0;
    else        txd_oe <= 1'b1;

  // receive queue
  logic [7:0]    rx_mem [DEPTH];
  logic [AW:0]   rx_wr, rx_rd;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rx_cnt8;
  logic          rx_full, rx_empty, rx_pop, rx_done, rx_bad, ferr;
  rx_st_e        rx_st;
  logic [3:0]    rx_tc;
  logic [2:0]    rx_bc;
  logic [7:0]    rx_sh;

  assign rx_cnt   = rx_wr - rx_rd;
  assign rx_cnt8  = 8'(rx_cnt);
  assign rx_full  = rx_cnt == FULL;
  assign rx_empty = rx_cnt == '0;
  assign rx_pop   = rd && addr == 3'd0 && !rx_empty;
  assign rx_done  = tick && rx_st == RX_STOP && rx_tc == 4'd15 &&  rxd_s;
  assign rx_bad   = tick && rx_st == RX_STOP && rx_tc == 4'd15 && !rxd_s;

  always_ff @(posedge clk)
    if (rx_done && !rx_full) rx_mem[rx_wr[AW-1:0]] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wr <= '0; rx_rd <= '0;
    end else begin
      if (rx_done && !rx_full) rx_wr <= rx_wr + 1'b1;
      if (rx_pop)              rx_rd <= rx_rd + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= RX_IDLE;
      rx_tc <= '0;
      rx_bc <= '0;
      rx_sh <= '0;
    end else if (rx_st == RX_BREAK) begin
      if (rxd_s) rx_st <= RX_IDLE;
    end else if (tick) begin
      case (rx_st)
        RX_IDLE:
          if (!rxd_s) begin
            rx_st <= RX_START;
            rx_tc <= '0;
          end
        RX_START:
          if (rx_tc == 4'd7) begin
            rx_tc <= '0;
            rx_bc <= '0;
            rx_st <= rxd_s ? RX_IDLE : RX_DATA;
          end else rx_tc <= rx_tc + 4'd1;
        RX_DATA:
          if (rx_tc == 4'd15) begin
            rx_tc <= '0;
            rx_sh <= {rxd_s, rx_sh[7:1]};
            if (rx_bc == 3'd7) rx_st <= RX_STOP;
            else               rx_bc <= rx_bc + 3'd1;
          end else rx_tc <= rx_tc + 4'd1;
        RX_STOP:
          if (rx_tc == 4'd15) begin
            rx_tc <= '0;
            rx_st <= rxd_s ? RX_IDLE : RX_BREAK;
          end else rx_tc <= rx_tc + 4'd1;
        default: rx_st <= RX_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ferr <= 1'b0;
    else if (rx_bad)  ferr <= 1'b1;
    else if (stat_rd) ferr <= 1'b0;

  // flow control and interrupts
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    rts <= 1'b1;
    else if (rx_cnt8 >= hwm_q)     rts <= 1'b0;
    else if (rx_cnt8 <  rx_thr_q)  rts <= 1'b1;

  wire rx_irq = !rx_empty && rx_cnt8 >= rx_thr_q;
  wire tx_irq = 8'(tx_cnt) <= tx_thr_q;
  assign irq = rx_irq | tx_irq;

  wire [7:0] status = {tx_busy, rts, tx_irq, rx_irq, ferr, tx_empty, tx_full, !rx_empty};

  always_comb
    case (addr)
      3'd0:    rdata = rx_mem[rx_rd[AW-1:0]];
      3'd1:    rdata = div_q[7:0];
      3'd2:    rdata = div_q[15:8];
      3'd3:    rdata = rx_thr_q;
      3'd4:    rdata = tx_thr_q;
      3'd5:    rdata = hwm_q;
      3'd6:    rdata = status;
      default: rdata = rx_cnt8;
    endcase

  AST_TX_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> $past(cts_s)); // R5
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL); // R3
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL); // R4
  AST_RTS_AT_HWM: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt8 >= hwm_q |=> !rts); // R6
  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (tx_busy && tx_bc == 4'd9) |-> txd); // R2
  AST_FERR_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n) $rose(ferr) |-> $past(rx_st == RX_STOP)); // R7
  AST_RX_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rx_full && !rx_pop) |=> $stable(rx_wr)); // R4
endmodule

// File: tb/uart_link_tb.sv
module uart_link_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cs, we, cts, loop_en, rxd_drv;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       txd, txd_oe, rts, irq, rxd;

  assign rxd = loop_en ? txd : rxd_drv;

  uart_link u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rxd(rxd), .cts(cts), .txd(txd), .txd_oe(txd_oe),
    .rts(rts), .irq(irq)
  );

  int checks = 0, errors = 0;

  // {divisor, byte}
  localparam logic [15:0] VEC [7] = '{16'h0155, 16'h0100, 16'h02FF, 16'h03A3,
                                      16'h0181, 16'h023C, 16'h00E7};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0;
  endtask

  task automatic get_frame(input int p, input bit drop, output logic [7:0] b, output bit good);
    int n = 0;
    good = 1;
    b = '0;
    while (txd !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin good = 0; return; end
    if (drop) cts = 0;
    repeat (p / 2) @(negedge clk);
    if (txd !== 1'b0) good = 0;
    for (int i = 0; i < 8; i++) begin
      repeat (p) @(negedge clk);
      b[i] = txd;
    end
    repeat (p) @(negedge clk);
    if (txd !== 1'b1) good = 0;
  endtask

  task automatic send_rx(input logic [7:0] b, input bit stop);
    @(negedge clk);
    rxd_drv = 0; repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd_drv = b[i]; repeat (16) @(negedge clk); end
    rxd_drv = stop; repeat (16) @(negedge clk);
    rxd_drv = 1; repeat (16) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d, b;
    bit good, all_high;
    rst_n = 0; cs = 0; we = 0; addr = 0; wdata = 0;
    cts = 1; loop_en = 1; rxd_drv = 1;
    repeat (3) @(negedge clk);
    chk(txd_oe == 0, "R1 txd_oe in reset", txd_oe, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(txd_oe == 1, "R1 txd_oe", txd_oe, 1);
    chk(txd == 1, "R1 txd idle", txd, 1);
    chk(rts == 1, "R1 rts", rts, 1);
    chk(irq == 1, "R1 irq", irq, 1);
    bus_rd(3'd1, d); chk(d == 8'd14, "R1 R10 divisor low", d, 14);
    bus_rd(3'd2, d); chk(d == 8'd0, "R1 R10 divisor high", d, 0);
    bus_rd(3'd5, d); chk(d == 8'd120, "R1 hwm", d, 120);
    bus_rd(3'd3, d); chk(d == 8'd1, "R1 rx threshold", d, 1);
    bus_rd(3'd6, d); chk(d == 8'h64, "R1 R10 status", d, 8'h64);

    // vector table: divisor and byte, looped back
    foreach (VEC[k]) begin
      automatic int dv = VEC[k][15:8];
      automatic int p = 16 * ((dv == 0) ? 1 : dv);
      bus_wr(3'd1, VEC[k][15:8]);
      bus_wr(3'd2, 8'd0);
      bus_wr(3'd0, VEC[k][7:0]);
      get_frame(p, 0, b, good);
      chk(good && b == VEC[k][7:0], "R2 frame on txd", b, VEC[k][7:0]);
      repeat (p) @(negedge clk);
      bus_rd(3'd0, d);
      chk(d == VEC[k][7:0], "R7 mid-bit receive", d, VEC[k][7:0]);
    end
    bus_wr(3'd1, 8'd1);

    // R5: no start while cts low
    cts = 0; repeat (4) @(negedge clk);
    bus_wr(3'd0, 8'h5A);
    all_high = 1;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (txd !== 1'b1) all_high = 0; end
    chk(all_high, "R5 held while cts low", all_high, 1);
    bus_rd(3'd6, d); chk(d[2] == 0, "R5 byte still queued", d[2], 0);
    cts = 1;
    get_frame(16, 0, b, good);
    chk(good && b == 8'h5A, "R5 sent after cts rises", b, 8'h5A);
    repeat (40) @(negedge clk);
    bus_rd(3'd0, d);

    // R5: byte in progress completes
    bus_wr(3'd0, 8'h11);
    bus_wr(3'd0, 8'h22);
    get_frame(16, 1, b, good);
    chk(good && b == 8'h11, "R5 in-progress byte completes", b, 8'h11);
    all_high = 1;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (txd !== 1'b1) all_high = 0; end
    chk(all_high, "R5 next byte held", all_high, 1);
    cts = 1;
    get_frame(16, 0, b, good);
    chk(good && b == 8'h22, "R5 second byte", b, 8'h22);
    repeat (40) @(negedge clk);
    bus_rd(3'd0, d); chk(d == 8'h11, "R4 order first", d, 8'h11);
    bus_rd(3'd0, d); chk(d == 8'h22, "R4 order second", d, 8'h22);

    // R9: transmit threshold
    cts = 0; repeat (4) @(negedge clk);
    bus_wr(3'd4, 8'd2);
    bus_wr(3'd0, 8'h01); bus_wr(3'd0, 8'h02);
    bus_rd(3'd6, d); chk(d[5] == 1, "R9 tx irq at threshold", d[5], 1);
    bus_wr(3'd0, 8'h03);
    bus_rd(3'd6, d); chk(d[5] == 0, "R9 tx irq above threshold", d[5], 0);
    chk(irq == 0, "R9 irq low", irq, 0);
    bus_wr(3'd4, 8'd200);
    bus_rd(3'd4, d); chk(d == 8'd128, "R9 threshold cap", d, 128);
    bus_wr(3'd4, 8'd0);
    bus_wr(3'd3, 8'd200);
    bus_rd(3'd3, d); chk(d == 8'd127, "R8 threshold cap", d, 127);
    bus_wr(3'd3, 8'd8);
    cts = 1;
    for (int i = 1; i <= 3; i++) begin
      get_frame(16, 0, b, good);
      chk(good && b == 8'(i), "R3 queue order", b, i);
    end
    repeat (40) @(negedge clk);
    for (int i = 0; i < 3; i++) bus_rd(3'd0, d);

    // R3/R4/R6/R8: fill both queues
    cts = 0; repeat (4) @(negedge clk);
    for (int i = 0; i < 130; i++) bus_wr(3'd0, 8'(i));
    bus_rd(3'd6, d); chk(d[1] == 1, "R3 tx full", d[1], 1);
    cts = 1;
    for (int i = 0; i < 128; i++) begin
      get_frame(16, 0, b, good);
      chk(good && b == 8'(i), "R3 tx order", b, i);
    end
    repeat (400) @(negedge clk);
    bus_rd(3'd6, d); chk(d[2] == 1 && txd == 1, "R3 overflow writes dropped", d[2], 1);
    bus_rd(3'd7, d); chk(d == 8'd128, "R4 rx fill", d, 128);
    chk(rts == 0, "R6 rts low at hwm", rts, 1'b0);
    bus_wr(3'd0, 8'hAA);
    get_frame(16, 0, b, good);
    repeat (40) @(negedge clk);
    bus_rd(3'd7, d); chk(d == 8'd128, "R4 byte dropped when full", d, 128);
    for (int k = 0; k < 128; k++) begin
      bus_rd(3'd0, d);
      chk(d == 8'(k), "R4 rx order", d, k);
      if (127 - k == 119) begin
        repeat (2) @(negedge clk);
        chk(rts == 0, "R6 rts holds below hwm", rts, 0);
      end
      if (127 - k == 8) begin
        repeat (2) @(negedge clk);
        bus_rd(3'd6, b);
        chk(b[4] == 1, "R8 rx irq at threshold", b[4], 1);
        chk(rts == 0, "R6 rts low at threshold", rts, 0);
      end
      if (127 - k == 7) begin
        repeat (2) @(negedge clk);
        bus_rd(3'd6, b);
        chk(b[4] == 0, "R8 rx irq below threshold", b[4], 0);
        chk(rts == 1, "R6 rts back high", rts, 1);
      end
    end
    bus_wr(3'd3, 8'd1);

    // R7: framing error
    loop_en = 0;
    send_rx(8'h3C, 0);
    bus_rd(3'd6, d);
    chk(d[3] == 1 && d[0] == 0, "R7 framing error, byte discarded", d, 8'h08);
    bus_rd(3'd6, d); chk(d[3] == 0, "R7 flag cleared by read", d[3], 0);
    send_rx(8'h96, 1);
    bus_rd(3'd7, d); chk(d == 8'd1, "R7 good byte after error", d, 1);
    bus_rd(3'd0, d); chk(d == 8'h96, "R7 data after error", d, 8'h96);

    // R11: short glitch
    @(negedge clk); rxd_drv = 0;
    repeat (4) @(negedge clk); rxd_drv = 1;
    repeat (200) @(negedge clk);
    bus_rd(3'd7, d); chk(d == 8'd0, "R11 glitch rejected", d, 0);
    send_rx(8'hC5, 1);
    bus_rd(3'd0, d); chk(d == 8'hC5, "R11 receive after glitch", d, 8'hC5);

    finish_run();
  end
endmodule